// File: doc/BRIEF.md
# Nestable Priority Interrupt Controller

This block collects interrupt requests from a set of source lines and presents one of them at a time to a processor core. Each source has its own priority value and its own enable bit. A numerically smaller value is more urgent. Value 1 outranks value 2, and so on. A rising edge on a source line latches a pending bit for that source. The controller offers the core the vector index of the most urgent enabled pending source and waits for the core to accept it. The core looks up the handler address from that index on its own. When a handler finishes, the core sends an end-of-service pulse.

A mode input selects how a new request is treated while a handler runs. With nesting on, a strictly more urgent request is offered at once. Once the core accepts it, the running handler is suspended on an internal stack of active handlers, and it becomes current again after the new handler ends. With nesting off, nothing is offered while any handler runs, whatever its priority. The stack holds one entry per priority level.

The sequencer has four states:
- `ST_IDLE`: no handler runs. It moves to `ST_OFFER` when an offerable source exists.
- `ST_RUN`: at least one handler runs. It moves to `ST_SETTLE` on end-of-service. Otherwise it moves to `ST_OFFER` when a pre-empting source exists.
- `ST_OFFER`: `cpu_req` is high. It moves to `ST_RUN` on acknowledge. It moves to `ST_SETTLE` on end-of-service from a running handler. It falls back to `ST_IDLE` or `ST_RUN` when the offer is no longer valid.
- `ST_SETTLE`: the one quiet cycle after a pop. It stays in `ST_SETTLE` on a further end-of-service. Otherwise it moves to `ST_OFFER`, `ST_RUN` or `ST_IDLE`.

Top module: `pic_nested_ctrl`

## Requirements
- R1: Among enabled pending sources, the one with the numerically smallest priority value is offered on `cpu_vec`.
- R2: When several enabled pending sources share the smallest priority value, the lowest source index is offered.
- R3: A pending bit is set only by a low-to-high transition of its source line. Acknowledging the offered source clears its pending bit. A line that stays high does not set the bit again, and `cpu_req` falls in the cycle after an acknowledge.
- R4: A disabled source keeps its pending bit but is never offered. Enabling it later makes it offerable.
- R5: With no handler running, `cpu_req` rises at the second rising clock edge after the source line rises, and not at the first.
- R6: With nesting on, a source that is strictly more urgent than the running handler is offered while that handler runs. After it is acknowledged it becomes the running handler (`run_vec`, `run_prio`). After its end-of-service, the suspended handler is current again.
- R7: With nesting on, a source whose priority value is equal to or larger than that of the running handler is not offered until that handler ends.
- R8: With nesting off, no source is offered while a handler runs, whatever its priority.
- R9: End-of-service pops the running handler. `cpu_req` stays low in the following cycle, and re-arbitration takes effect the cycle after that.
- R10: After reset, `cpu_req` and `run_valid` are low and no source is pending.
- R11: End-of-service while no handler runs has no effect: `run_valid` stays low and later handling is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nest_en | input | 1 | 1 = nested pre-emption, 0 = run to completion |
| irq_in | input | NUM_SRC | Source request lines, rising edge latches pending |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*PRIO_W | Priority value of source i at bits [i*PRIO_W +: PRIO_W], smaller is more urgent |
| cpu_ack | input | 1 | Core accepts the offered vector |
| cpu_eos | input | 1 | Core finished the running handler |
| cpu_req | output | 1 | Offer to the core is valid |
| cpu_vec | output | IDX_W | Index of the offered source |
| run_valid | output | 1 | At least one handler is active |
| run_vec | output | IDX_W | Index of the current running handler |
| run_prio | output | PRIO_W | Priority value of the current running handler |

## Verification
Arbitration is tried with two sources of different priority raised in the same cycle, which distinguishes value ordering from index ordering. Two sources of equal priority raised together isolate the tie-break. A more urgent arrival during a running handler is applied once with nesting on and once with nesting off, which separates pre-emption from run-to-completion. The resume check then confirms that the stack returns the suspended handler. Equal-priority arrivals, a disabled source that is enabled later, a line held high across its acknowledge, and a stray end-of-service while idle each exercise one of the rules that must not fire.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // sequencer states of the controller
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_OFFER  = 2'd2,
        ST_SETTLE = 2'd3
    } pic_state_e;

endpackage

// File: rtl/pic_pending.sv
module pic_pending #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr_mask;

    always_comb begin
        rise     = irq_in & ~irq_q;
        clr_mask = '0;
        if (clr_en) begin
            clr_mask[clr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            pend  <= '0;
        end else begin
            irq_q <= irq_in;
            // a fresh edge wins over a clear in the same cycle
            pend  <= (pend & ~clr_mask) | rise;
        end
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    output logic                      best_valid,
    output logic [IDX_W-1:0]          best_idx,
    output logic [PRIO_W-1:0]         best_prio
);

    logic [PRIO_W-1:0] prio_arr [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign prio_arr[g] = src_prio[g*PRIO_W +: PRIO_W];
    end

    // linear scan: strict compare keeps the lowest index on a tie
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_prio  = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && src_en[i] && (!best_valid || prio_arr[i] < best_prio)) begin
                best_valid = 1'b1;
                best_idx   = IDX_W'(i);
                best_prio  = prio_arr[i];
            end
        end
    end

endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack #(
    parameter int LEVELS = 8,
    parameter int IDX_W  = 3,
    parameter int PRIO_W = 3,
    localparam int ADDR_W = $clog2(LEVELS),
    localparam int SP_W   = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [IDX_W-1:0]  top_idx,
    output logic [PRIO_W-1:0] top_prio
);

    logic [IDX_W-1:0]  idx_mem  [LEVELS];
    logic [PRIO_W-1:0] prio_mem [LEVELS];
    logic [SP_W-1:0]   sp;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    always_comb begin
        wr_ptr   = sp[ADDR_W-1:0];
        rd_ptr   = wr_ptr - ADDR_W'(1);
        empty    = (sp == '0);
        full     = (sp == SP_W'(LEVELS));
        top_idx  = empty ? '0 : idx_mem[rd_ptr];
        top_prio = empty ? '1 : prio_mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < LEVELS; i++) begin
                idx_mem[i]  <= '0;
                prio_mem[i] <= '0;
            end
        end else if (push && !full) begin
            idx_mem[wr_ptr]  <= push_idx;
            prio_mem[wr_ptr] <= push_prio;
            sp               <= sp + SP_W'(1);
        end else if (pop && !empty) begin
            sp <= sp - SP_W'(1);
        end
    end

endmodule

// File: rtl/pic_nested_ctrl.sv
module pic_nested_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int LEVELS = 1 << PRIO_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      nest_en,
    input  logic [NUM_SRC-1:0]        irq_in,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      cpu_ack,
    input  logic                      cpu_eos,
    output logic                      cpu_req,
    output logic [IDX_W-1:0]          cpu_vec,
    output logic                      run_valid,
    output logic [IDX_W-1:0]          run_vec,
    output logic [PRIO_W-1:0]         run_prio
);

    pic_state_e        state, state_n;
    logic [IDX_W-1:0]  offer_idx;
    logic [PRIO_W-1:0] offer_prio;

    logic [NUM_SRC-1:0] pend;
    logic               best_valid;
    logic [IDX_W-1:0]   best_idx;
    logic [PRIO_W-1:0]  best_prio;
    logic               stk_empty;
    logic               stk_full;
    logic [IDX_W-1:0]   top_idx;
    logic [PRIO_W-1:0]  top_prio;
    logic               offer_ok;
    logic               take;
    logic               drop;

    pic_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .clr_en  (take),
        .clr_idx (offer_idx),
        .pend    (pend)
    );

    pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .pend       (pend),
        .src_en     (src_en),
        .src_prio   (src_prio),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_prio  (best_prio)
    );

    pic_prio_stack #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_idx  (offer_idx),
        .push_prio (offer_prio),
        .pop       (drop),
        .empty     (stk_empty),
        .full      (stk_full),
        .top_idx   (top_idx),
        .top_prio  (top_prio)
    );

    // next-state logic
    always_comb begin
        offer_ok = best_valid && !stk_full &&
                   (stk_empty || (nest_en && (best_prio < top_prio)));
        state_n  = state;
        unique case (state)
            ST_IDLE: begin
                if (offer_ok) state_n = ST_OFFER;
            end
            ST_RUN: begin
                if (cpu_eos)       state_n = ST_SETTLE;
                else if (offer_ok) state_n = ST_OFFER;
            end
            ST_OFFER: begin
                if (cpu_ack)                      state_n = ST_RUN;
                else if (cpu_eos && !stk_empty)   state_n = ST_SETTLE;
                else if (!offer_ok)               state_n = stk_empty ? ST_IDLE : ST_RUN;
            end
            ST_SETTLE: begin
                if (cpu_eos && !stk_empty) state_n = ST_SETTLE;
                else if (offer_ok)         state_n = ST_OFFER;
                else                       state_n = stk_empty ? ST_IDLE : ST_RUN;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and latched offer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            offer_idx  <= '0;
            offer_prio <= '0;
        end else begin
            state <= state_n;
            if (state_n == ST_OFFER) begin
                offer_idx  <= best_idx;
                offer_prio <= best_prio;
            end
        end
    end

    // outputs and strobes
    always_comb begin
        cpu_req   = (state == ST_OFFER);
        cpu_vec   = offer_idx;
        take      = cpu_req && cpu_ack;
        drop      = cpu_eos && !stk_empty && (state != ST_IDLE) && !take;
        run_valid = !stk_empty;
        run_vec   = top_idx;
        run_prio  = top_prio;
    end

endmodule

// File: rtl/pic_nested_ctrl_chk.sv
module pic_nested_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      nest_en,
    input logic [NUM_SRC-1:0]        src_en,
    input logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input logic                      cpu_ack,
    input logic                      cpu_eos,
    input logic                      cpu_req,
    input logic [IDX_W-1:0]          cpu_vec,
    input logic                      run_valid,
    input logic [PRIO_W-1:0]         run_prio
);

    logic [PRIO_W-1:0] offer_p;
    assign offer_p = src_prio[int'(cpu_vec)*PRIO_W +: PRIO_W];

    // R6 / R7: an offer made during service must outrank the running handler
    a_r6_offer_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && run_valid && $stable(src_prio)) |-> (offer_p < run_prio));

    // R8: run to completion keeps the request low
    a_r8_no_offer_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && $past(!nest_en) && run_valid) |-> !cpu_req);

    // R9: quiet cycle after a pop
    a_r9_gap_after_eos: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eos && run_valid && !cpu_ack) |=> !cpu_req);

    // R4: only enabled sources are offered
    a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && $stable(src_en)) |-> src_en[cpu_vec]);

    // R3: acceptance withdraws the offer
    a_r3_ack_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> !cpu_req);

endmodule

bind pic_nested_ctrl pic_nested_ctrl_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nest_en   (nest_en),
    .src_en    (src_en),
    .src_prio  (src_prio),
    .cpu_ack   (cpu_ack),
    .cpu_eos   (cpu_eos),
    .cpu_req   (cpu_req),
    .cpu_vec   (cpu_vec),
    .run_valid (run_valid),
    .run_prio  (run_prio)
);

// File: tb/pic_nested_ctrl_tb.sv
`timescale 1ns/1ps
module pic_nested_ctrl_tb;

    localparam int NUM_SRC = 8;
    localparam int PRIO_W  = 3;
    localparam int IDX_W   = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      nest_en = 1'b1;
    logic [NUM_SRC-1:0]        irq_in = '0;
    logic [NUM_SRC-1:0]        src_en = '1;
    logic [NUM_SRC*PRIO_W-1:0] src_prio;
    logic                      cpu_ack = 1'b0;
    logic                      cpu_eos = 1'b0;
    logic                      cpu_req;
    logic [IDX_W-1:0]          cpu_vec;
    logic                      run_valid;
    logic [IDX_W-1:0]          run_vec;
    logic [PRIO_W-1:0]         run_prio;

    logic [PRIO_W-1:0] prio_a [NUM_SRC];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) src_prio[i*PRIO_W +: PRIO_W] = prio_a[i];
    end

    pic_nested_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .nest_en(nest_en), .irq_in(irq_in),
        .src_en(src_en), .src_prio(src_prio), .cpu_ack(cpu_ack), .cpu_eos(cpu_eos),
        .cpu_req(cpu_req), .cpu_vec(cpu_vec), .run_valid(run_valid),
        .run_vec(run_vec), .run_prio(run_prio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] m);
        irq_in = irq_in | m;
        tick(1);
        irq_in = irq_in & ~m;
        tick(1);
    endtask

    task automatic do_ack();
        cpu_ack = 1'b1;
        tick(1);
        cpu_ack = 1'b0;
    endtask

    task automatic do_eos();
        cpu_eos = 1'b1;
        tick(1);
        cpu_eos = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 req after reset", cpu_req, 0);
        chk("R10 run_valid after reset", run_valid, 0);
        tick(2);
        chk("R10 nothing pending", cpu_req, 0);
    endtask

    task automatic t_level_hold();
        prio_a[3] = 4;
        irq_in[3] = 1'b1;
        tick(1);
        chk("R5 no req after first edge", cpu_req, 0);
        tick(1);
        chk("R5 req after second edge", cpu_req, 1);
        chk("R5 vec", cpu_vec, 3);
        do_ack();
        chk("R3 req drops after ack", cpu_req, 0);
        chk("R3 run_vec", run_vec, 3);
        tick(2);
        chk("R3 held line no re-pend", cpu_req, 0);
        do_eos();
        tick(2);
        chk("R3 idle after eos", run_valid, 0);
        chk("R3 no re-offer", cpu_req, 0);
        irq_in[3] = 1'b0;
        tick(2);
    endtask

    task automatic t_priority();
        prio_a[1] = 5;
        prio_a[6] = 2;
        pulse(8'b0100_0010);
        chk("R1 lower value wins", cpu_vec, 6);
        do_ack();
        chk("R7 lower priority waits", cpu_req, 0);
        do_eos();
        chk("R9 quiet after eos", cpu_req, 0);
        chk("R9 popped", run_valid, 0);
        tick(1);
        chk("R9 re-arbitrated req", cpu_req, 1);
        chk("R1 second source", cpu_vec, 1);
        do_ack();
        do_eos();
        tick(2);
    endtask

    task automatic t_tie();
        prio_a[2] = 3;
        prio_a[5] = 3;
        pulse(8'b0010_0100);
        chk("R2 lowest index wins", cpu_vec, 2);
        do_ack();
        do_eos();
        tick(1);
        chk("R2 other tie source next", cpu_vec, 5);
        chk("R2 req", cpu_req, 1);
        do_ack();
        do_eos();
        tick(2);
    endtask

    task automatic t_nested();
        prio_a[4] = 6;
        prio_a[0] = 1;
        pulse(8'b0001_0000);
        do_ack();
        pulse(8'b0000_0001);
        chk("R6 preempt req", cpu_req, 1);
        chk("R6 preempt vec", cpu_vec, 0);
        do_ack();
        chk("R6 new runner", run_vec, 0);
        chk("R6 new runner prio", run_prio, 1);
        do_eos();
        chk("R6 resumed vec", run_vec, 4);
        chk("R6 resumed prio", run_prio, 6);
        tick(1);
        chk("R6 no spurious req", cpu_req, 0);
        do_eos();
        tick(2);
        chk("R6 stack drained", run_valid, 0);
    endtask

    task automatic t_equal();
        prio_a[4] = 6;
        prio_a[7] = 6;
        pulse(8'b0001_0000);
        do_ack();
        pulse(8'b1000_0000);
        tick(2);
        chk("R7 equal no preempt", cpu_req, 0);
        do_eos();
        tick(1);
        chk("R7 equal served after", cpu_vec, 7);
        do_ack();
        do_eos();
        tick(2);
    endtask

    task automatic t_nonnested();
        nest_en = 1'b0;
        prio_a[4] = 6;
        prio_a[0] = 1;
        pulse(8'b0001_0000);
        do_ack();
        pulse(8'b0000_0001);
        tick(3);
        chk("R8 no preempt", cpu_req, 0);
        chk("R8 runner kept", run_vec, 4);
        do_eos();
        tick(1);
        chk("R8 served after finish", cpu_req, 1);
        chk("R8 vec", cpu_vec, 0);
        do_ack();
        do_eos();
        tick(2);
        nest_en = 1'b1;
        tick(1);
    endtask

    task automatic t_disabled();
        prio_a[5] = 3;
        src_en[5] = 1'b0;
        pulse(8'b0010_0000);
        tick(3);
        chk("R4 disabled not offered", cpu_req, 0);
        src_en[5] = 1'b1;
        tick(1);
        chk("R4 offered once enabled", cpu_req, 1);
        chk("R4 vec", cpu_vec, 5);
        do_ack();
        do_eos();
        tick(2);
    endtask

    task automatic t_stray_eos();
        do_eos();
        tick(1);
        chk("R11 stray eos run_valid", run_valid, 0);
        chk("R11 stray eos req", cpu_req, 0);
        prio_a[3] = 2;
        pulse(8'b0000_1000);
        chk("R11 later offer", cpu_vec, 3);
        do_ack();
        chk("R11 runs", run_valid, 1);
        do_eos();
        tick(1);
        chk("R11 single pop empties", run_valid, 0);
        tick(2);
    endtask

    initial begin
        for (int i = 0; i < NUM_SRC; i++) prio_a[i] = 7;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_level_hold();
        t_priority();
        t_tie();
        t_nested();
        t_equal();
        t_nonnested();
        t_disabled();
        t_stray_eos();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule